// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block follows the life of a single SDRAM bank by watching the command pins of the memory interface. On every clock edge it samples chip select, row strobe, column strobe, write enable, clock enable and the auto-precharge address bit. It then moves the bank through its eight states and flags any command that the bank cannot accept in the state it is in. A controller or a protocol monitor places one instance per bank. It reads the state code and the busy flag to schedule traffic, and it uses the illegal-command pulse to catch sequencing faults.

The states that are timed run from one shared down-counter. The counter is loaded from programmable cycle counts: row-to-column delay, precharge time and burst length. The block has no data path and no streaming interface. All pins are plain level signals, so there is no handshake and no back-pressure.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset the state code is 0 (Idle), `busy_o` is low and `illegal_o` is low.
- R2: The command on {cs_n, ras_n, cas_n, we_n} decodes as follows. cs_n high is inhibit. With cs_n low, 0111 is NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 BURST TERMINATE, 0010 PRECHARGE, 0001 AUTO REFRESH and 0000 LOAD MODE. A command acts only when cke is high at the current edge and was high at the previous edge. In every other case the command changes nothing and flags nothing. The cke history is low out of reset.
- R3: ACTIVE in Idle enters Activating (code 1). After `t_rcd` cycles the bank moves to Row Active (code 2). A count of 0 behaves as 1.
- R4: PRECHARGE in Row Active, Read or Write enters Precharging (code 5). After `t_rp` cycles the bank moves to Idle.
- R5: In Row Active, READ or WRITE with `auto_pre` low enters Read (code 3) or Write (code 4). If no command ends the burst, the bank returns to Row Active after `t_burst` cycles.
- R6: READ or WRITE with `auto_pre` high enters Read-AP (code 6) or Write-AP (code 7). After `t_burst + t_rp` cycles the bank moves to Idle.
- R7: In codes 1, 5, 6 and 7, `busy_o` is high. Any command other than NOP or inhibit raises `illegal_o` and leaves the state and its timing unchanged.
- R8: In Read or Write, READ or WRITE restarts a full burst in the new direction. BURST TERMINATE returns the bank to Row Active.
- R9: In Idle, AUTO REFRESH, LOAD MODE and PRECHARGE are legal and leave the bank in Idle. READ, WRITE and BURST TERMINATE are illegal.
- R10: In Row Active, ACTIVE, AUTO REFRESH, LOAD MODE and BURST TERMINATE are illegal. In Read or Write, ACTIVE, AUTO REFRESH and LOAD MODE are illegal. An illegal command leaves the state unchanged.
- R11: NOP and inhibit never raise `illegal_o`. Each offending command raises `illegal_o` for exactly the one cycle after the edge that sampled it.
- R12: If a burst ends on the same edge that samples a legal READ or WRITE, the command wins and a new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin as sampled |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| auto_pre | input | 1 | Auto-precharge bit of the column address |
| t_rcd | input | CNT_W | Activate-to-column delay in cycles |
| t_rp | input | CNT_W | Precharge time in cycles |
| t_burst | input | CNT_W | Burst length in cycles |
| state_o | output | 3 | Bank state code |
| busy_o | output | 1 | Bank in a timed state that accepts only NOP |
| illegal_o | output | 1 | One-cycle pulse for an illegal command |

## Verification
Two functions can fall on the same edge, and the bench drives both cases on purpose.

The first case is a burst that times out on the very edge that samples a fresh READ. The bench counts the burst cycles so that the READ lands on that edge. It expects code 3 rather than a return to Row Active.

The second case is an illegal command sent during a timed state, in the same window as the timer runs. The scoreboard expects the illegal pulse, and it expects the exit from the timed state on the same cycle as an undisturbed run.

// File: rtl/bktrk_pkg.sv
package bktrk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACTV = 3'd1,
    ST_OPEN = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4,
    ST_PRE  = 3'd5,
    ST_RDAP = 3'd6,
    ST_WRAP = 3'd7
  } bank_st_t;

  typedef enum logic [2:0] {
    C_NOP,
    C_ACT,
    C_RD,
    C_WR,
    C_BST,
    C_PRE,
    C_REF,
    C_LMR
  } bank_cmd_t;

  // States in which only NOP or inhibit may reach the bank
  function automatic logic st_locked(input bank_st_t s);
    return (s == ST_ACTV) || (s == ST_PRE) || (s == ST_RDAP) || (s == ST_WRAP);
  endfunction

endpackage

// File: rtl/bktrk_decode.sv
module bktrk_decode
  import bktrk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output bank_cmd_t cmd,
  output logic      live
);

  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    if (cs_n) begin
      cmd = C_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = C_LMR;
      endcase
    end
  end

  // A command counts only with the clock enabled now and one edge ago
  assign live = cke_q && cke && (cmd != C_NOP);

endmodule

// File: rtl/bktrk_timer.sv
module bktrk_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W:0]   load_val,
  output logic         expire
);

  logic [W:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? {{W{1'b0}}, 1'b1} : load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == {{W{1'b0}}, 1'b1});

endmodule

// File: rtl/bktrk_fsm.sv
module bktrk_fsm
  import bktrk_pkg::*;
#(
  parameter int W = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bank_cmd_t cmd,
  input  logic      live,
  input  logic      auto_pre,
  input  logic      expire,
  input  logic [W-1:0] t_rcd,
  input  logic [W-1:0] t_rp,
  input  logic [W-1:0] t_burst,
  output bank_st_t  state,
  output logic      tm_load,
  output logic [W:0] tm_val,
  output logic      illegal
);

  localparam int LW = W + 1;

  bank_st_t   st_q, st_d;
  logic       bad;
  logic [LW-1:0] rcd_x, rp_x, bl_x, blrp_x;

  assign rcd_x  = {1'b0, t_rcd};
  assign rp_x   = {1'b0, t_rp};
  assign bl_x   = {1'b0, t_burst};
  assign blrp_x = bl_x + rp_x;

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    bad     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (live) begin
          unique case (cmd)
            C_ACT: begin
              st_d    = ST_ACTV;
              tm_load = 1'b1;
              tm_val  = rcd_x;
            end
            C_REF, C_LMR, C_PRE: st_d = ST_IDLE;
            default: bad = 1'b1;
          endcase
        end
      end
      ST_ACTV: begin
        bad = live;
        if (expire) st_d = ST_OPEN;
      end
      ST_PRE, ST_RDAP, ST_WRAP: begin
        bad = live;
        if (expire) st_d = ST_IDLE;
      end
      ST_OPEN, ST_RD, ST_WR: begin
        if ((st_q != ST_OPEN) && expire) st_d = ST_OPEN;
        if (live) begin
          unique case (cmd)
            C_RD, C_WR: begin
              tm_load = 1'b1;
              if (auto_pre) begin
                st_d   = (cmd == C_RD) ? ST_RDAP : ST_WRAP;
                tm_val = blrp_x;
              end else begin
                st_d   = (cmd == C_RD) ? ST_RD : ST_WR;
                tm_val = bl_x;
              end
            end
            C_PRE: begin
              st_d    = ST_PRE;
              tm_load = 1'b1;
              tm_val  = rp_x;
            end
            C_BST: begin
              if (st_q == ST_OPEN) bad = 1'b1;
              else                 st_d = ST_OPEN;
            end
            default: bad = 1'b1;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      illegal <= 1'b0;
    end else begin
      st_q    <= st_d;
      illegal <= bad;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import bktrk_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             auto_pre,
  input  logic [CNT_W-1:0] t_rcd,
  input  logic [CNT_W-1:0] t_rp,
  input  logic [CNT_W-1:0] t_burst,
  output logic [2:0]       state_o,
  output logic             busy_o,
  output logic             illegal_o
);

  bank_cmd_t    cmd;
  logic         live;
  logic         tm_load;
  logic [CNT_W:0] tm_val;
  logic         expire;
  bank_st_t     st;

  bktrk_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd),
    .live  (live)
  );

  bktrk_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expire   (expire)
  );

  bktrk_fsm #(.W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .live     (live),
    .auto_pre (auto_pre),
    .expire   (expire),
    .t_rcd    (t_rcd),
    .t_rp     (t_rp),
    .t_burst  (t_burst),
    .state    (st),
    .tm_load  (tm_load),
    .tm_val   (tm_val),
    .illegal  (illegal_o)
  );

  assign state_o = st;
  assign busy_o  = st_locked(st);

endmodule

// File: rtl/bktrk_checker.sv
module bktrk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [2:0] state_o,
  input logic       busy_o,
  input logic       illegal_o
);

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1)); // R9

  AST_ACTV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd2)); // R3

  AST_PRE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |=> (state_o == 3'd5 || state_o == 3'd0)); // R4

  AST_AP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6 || state_o == 3'd7) |=> (state_o == $past(state_o) || state_o == 3'd0)); // R6

  AST_ILLEGAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($past(cke) && !$past(cs_n) && !($past(ras_n) && $past(cas_n) && $past(we_n)))); // R11

  AST_OPEN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && cs_n) |=> (state_o == 3'd2 && !illegal_o)); // R10

  AST_LOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && illegal_o) |-> $past(busy_o)); // R7

endmodule

bind sdram_bank_tracker bktrk_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .state_o   (state_o),
  .busy_o    (busy_o),
  .illegal_o (illegal_o)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;

  localparam int W = 6;

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_ACT = 4'b0011;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_BST = 4'b0110;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_LMR = 4'b0000;
  localparam logic [3:0] K_INH = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic auto_pre = 1'b0;
  logic [W-1:0] t_rcd = 6'd3, t_rp = 6'd2, t_burst = 6'd4;
  logic [2:0] state_o;
  logic busy_o, illegal_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [2:0] st;
    logic       ill;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  sdram_bank_tracker #(.CNT_W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .auto_pre  (auto_pre),
    .t_rcd     (t_rcd),
    .t_rp      (t_rp),
    .t_burst   (t_burst),
    .state_o   (state_o),
    .busy_o    (busy_o),
    .illegal_o (illegal_o)
  );

  function automatic logic locked(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd5) || (s == 3'd6) || (s == 3'd7);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Driver: sets the pins after an edge, queues what must show after the next edge
  task automatic step(input logic [3:0] c, input logic ap, input logic ck,
                      input logic [2:0] es, input logic ei, input string tag);
    exp_t e;
    @(posedge clk);
    #5;
    {cs_n, ras_n, cas_n, we_n} = c;
    auto_pre = ap;
    cke = ck;
    e.due = cyc + 1;
    e.st  = es;
    e.ill = ei;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [3:0] c, input logic [2:0] es, input logic ei, input string tag);
    step(c, 1'b0, 1'b1, es, ei, tag);
  endtask

  task automatic nop(input logic [2:0] es, input string tag);
    step(K_NOP, 1'b0, 1'b1, es, 1'b0, tag);
  endtask

  // Monitor: compares the oldest due item away from the edge
  always @(posedge clk) begin
    #12;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "state", int'(state_o), int'(e.st));
      chk(e.tag, "busy", int'(busy_o), int'(locked(e.st)));
      chk(e.tag, "illegal", int'(illegal_o), int'(e.ill));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);

    // R2: cke history is low out of reset, so this ACTIVE is dropped
    cmd(K_ACT, 3'd0, 1'b0, "R2");
    nop(3'd0, "R2");

    // R3 / R7 / R11: activation with a stray READ and an inhibit inside
    cmd(K_ACT, 3'd1, 1'b0, "R3");
    cmd(K_RD,  3'd1, 1'b1, "R7");
    cmd(K_INH, 3'd1, 1'b0, "R11");
    nop(3'd2, "R3");

    // R10: terminate without a burst is illegal in Row Active
    cmd(K_BST, 3'd2, 1'b1, "R10");
    nop(3'd2, "R11");

    // R5: read burst runs out by itself
    cmd(K_RD, 3'd3, 1'b0, "R5");
    nop(3'd3, "R5");
    nop(3'd3, "R5");
    nop(3'd3, "R5");
    nop(3'd2, "R5");

    // R8: a second READ restarts the full burst
    cmd(K_RD, 3'd3, 1'b0, "R8");
    nop(3'd3, "R8");
    cmd(K_RD, 3'd3, 1'b0, "R8");
    nop(3'd3, "R8");
    nop(3'd3, "R8");
    nop(3'd3, "R8");
    nop(3'd2, "R8");

    // R10 / R8: refresh inside a write is illegal, terminate ends it
    cmd(K_WR,  3'd4, 1'b0, "R5");
    cmd(K_REF, 3'd4, 1'b1, "R10");
    cmd(K_BST, 3'd2, 1'b0, "R8");

    // R12: READ on the edge where the write burst times out
    cmd(K_WR, 3'd4, 1'b0, "R12");
    nop(3'd4, "R12");
    nop(3'd4, "R12");
    nop(3'd4, "R12");
    cmd(K_RD, 3'd3, 1'b0, "R12");
    cmd(K_BST, 3'd2, 1'b0, "R8");

    // R4 / R7: precharge with a LOAD MODE inside
    cmd(K_PRE, 3'd5, 1'b0, "R4");
    cmd(K_LMR, 3'd5, 1'b1, "R7");
    nop(3'd0, "R4");

    // R9: idle command set
    cmd(K_WR,  3'd0, 1'b1, "R9");
    cmd(K_BST, 3'd0, 1'b1, "R9");
    cmd(K_REF, 3'd0, 1'b0, "R9");
    cmd(K_LMR, 3'd0, 1'b0, "R9");
    cmd(K_PRE, 3'd0, 1'b0, "R9");

    // R2: clock enable low now, then low one edge ago
    step(K_ACT, 1'b0, 1'b0, 3'd0, 1'b0, "R2");
    step(K_RD,  1'b0, 1'b1, 3'd0, 1'b0, "R2");
    nop(3'd0, "R2");

    // R6 / R7: read with auto precharge, stray WRITE inside
    cmd(K_ACT, 3'd1, 1'b0, "R3");
    nop(3'd1, "R3");
    nop(3'd1, "R3");
    nop(3'd2, "R3");
    step(K_RD, 1'b1, 1'b1, 3'd6, 1'b0, "R6");
    nop(3'd6, "R6");
    cmd(K_WR, 3'd6, 1'b1, "R7");
    nop(3'd6, "R6");
    nop(3'd6, "R6");
    nop(3'd6, "R6");
    nop(3'd0, "R6");

    // R6 / R4: write with auto precharge from a write burst, then precharge from Write
    cmd(K_ACT, 3'd1, 1'b0, "R3");
    nop(3'd1, "R3");
    nop(3'd1, "R3");
    nop(3'd2, "R3");
    cmd(K_WR, 3'd4, 1'b0, "R5");
    cmd(K_PRE, 3'd5, 1'b0, "R4");
    nop(3'd5, "R4");
    nop(3'd0, "R4");

    // R3: zero activation delay behaves as one cycle
    t_rcd = 6'd0;
    cmd(K_ACT, 3'd1, 1'b0, "R3");
    nop(3'd2, "R3");
    step(K_WR, 1'b1, 1'b1, 3'd7, 1'b0, "R6");
    nop(3'd7, "R6");
    nop(3'd7, "R6");
    nop(3'd7, "R6");
    nop(3'd7, "R6");
    nop(3'd7, "R6");
    nop(3'd0, "R6");

    repeat (3) @(posedge clk);
    #15;
    if (q.size() != 0) chk("R11", "pending", q.size(), 0);
    finish_run();
  end

endmodule